// File: doc/BRIEF.md
# Banked System-Control Register File

This block holds the system-control registers of a small multithreaded core. A register is addressed by a flat 8-bit index, formed as the register number times eight plus a 3-bit select. Each implemented register lives in one of three banking classes. A shared register has a single copy. A per-thread register has one copy for each hardware thread. A per-virtual-processor register has one copy for each virtual processor. The copy that a thread reaches in a per-virtual-processor register is chosen by the virtual-processor number held in that thread's own binding register.

There are two write ports. The masked port merges new data through a fixed per-register writable-bit mask. The raw port stores data unchanged. Reads are combinational.

Any accepted masked write arms a deferred run/halt evaluation for the following cycle. That evaluation turns each thread's halt flag and activated flag into one bit of a run vector.

Top module: `ctl_reg_bank`

## Requirements
- R1: The flat index is register number × 8 + select. An index outside the implemented set (for example 5) reads as zero, and writes to it through either port are ignored.
- R2: Per-thread registers choose their copy by the accessing thread id. These are thread_state (17), thread_bind (18), thread_halt (20), core_status (96) and the other per-thread entries.
- R3: Per-virtual-processor registers choose their copy by bits [3:0] of the accessing thread's thread_bind. These are vp_cfg (10), exc_base (121) and the other per-virtual-processor entries. A value of NUM_VP or above selects copy 0.
- R4: A masked write stores (data & mask) | (old & ~mask). Examples of masks: core_status 0xFF78FF17, irq_ctl (97) 0x000003E0, exc_base 0x3FFFF000. proc_id (120) and rand_idx (8) have mask 0 and are read-only. Registers without a listed mask are fully writable.
- R5: The raw port stores its data unchanged in every bit, including the bits of read-only registers.
- R6: When both ports hit the same index and copy in one cycle, only the masked write takes effect. It merges against the value held before that cycle.
- R7: Reset values are as follows. core_status has bit 2 and bit 22 set (0x00400004). rand_idx holds 63. exc_base has bit 31 set. mp_cfg (2) holds bit 15 set, [13:10] = NUM_VP−1 and [7:0] = NUM_TC−1. vp_cfg has bit 1 set. The thread_bind of thread t holds t in [28:21]. thread_halt bit 0 is 0.
- R8: At reset, thread 0's thread_state has bit 13 (activated) set. Every other thread's thread_state has bit 15 (dynamically allocatable) set.
- R9: A masked write to an implemented index raises eval_pending_o after that edge. run_o changes at the following edge, and pending then clears. Raw writes never schedule an evaluation.
- R10: A masked write accepted while an evaluation is pending schedules no second evaluation. The evaluation uses the state held before that write.
- R11: During evaluation, thread t with t ≤ mp_cfg[7:0] runs when thread_halt bit 0 is 0 and thread_state bit 13 is 1, and halts otherwise. Threads above that limit keep their previous run bit.
- R12: After reset, run_o has only bit 0 set and eval_pending_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_idx_i | input | 8 | Read flat index |
| rd_tc_i | input | TCW | Reading thread id |
| rd_data_o | output | 32 | Read data, combinational |
| wr_en_i | input | 1 | Masked write enable |
| wr_idx_i | input | 8 | Masked write flat index |
| wr_tc_i | input | TCW | Masked writing thread id |
| wr_data_i | input | 32 | Masked write data |
| raw_en_i | input | 1 | Raw write enable |
| raw_idx_i | input | 8 | Raw write flat index |
| raw_tc_i | input | TCW | Raw writing thread id |
| raw_data_i | input | 32 | Raw write data |
| run_o | output | NUM_TC | Per-thread run vector |
| eval_pending_o | output | 1 | Deferred evaluation armed |

## Verification
Masked writes are driven with all-ones and all-zeros data into registers whose masks differ. This separates a merge from a plain store, and it shows that read-only registers ignore the masked port but not the raw port. A same-cycle collision uses complementary data on the two ports, so that "masked wins", "raw wins" and "merged against the raw value" each give a different readback. Banking is exercised by writing through one thread and reading through another, and by retargeting a thread's virtual-processor binding, including an out-of-range value. The run vector is tried with a halt set, a halt cleared through the raw port with no effect until a later masked write, back-to-back masked writes, and a reduced thread limit.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned NUM_IDX = 1 << IDX_W;

  typedef enum logic [1:0] {BK_NONE, BK_ONE, BK_VP, BK_TC} bank_e;

  // flat index = reg*8 + sel
  localparam logic [7:0] IDX_TLB_INDEX = 8'd0;
  localparam logic [7:0] IDX_MP_CTL    = 8'd1;
  localparam logic [7:0] IDX_MP_CFG    = 8'd2;
  localparam logic [7:0] IDX_RAND      = 8'd8;
  localparam logic [7:0] IDX_VP_CFG    = 8'd10;
  localparam logic [7:0] IDX_ENTLO0    = 8'd16;
  localparam logic [7:0] IDX_TSTATE    = 8'd17;
  localparam logic [7:0] IDX_TBIND     = 8'd18;
  localparam logic [7:0] IDX_THALT     = 8'd20;
  localparam logic [7:0] IDX_ENTLO1    = 8'd24;
  localparam logic [7:0] IDX_CTX       = 8'd32;
  localparam logic [7:0] IDX_PGMASK    = 8'd40;
  localparam logic [7:0] IDX_WIRED     = 8'd48;
  localparam logic [7:0] IDX_BADVA     = 8'd64;
  localparam logic [7:0] IDX_STATUS    = 8'd96;
  localparam logic [7:0] IDX_IRQCTL    = 8'd97;
  localparam logic [7:0] IDX_SHADOW    = 8'd98;
  localparam logic [7:0] IDX_CAUSE     = 8'd104;
  localparam logic [7:0] IDX_PROCID    = 8'd120;
  localparam logic [7:0] IDX_EXCBASE   = 8'd121;
  localparam logic [7:0] IDX_CFG0      = 8'd128;
  localparam logic [7:0] IDX_CFG1      = 8'd129;
  localparam logic [7:0] IDX_CFG2      = 8'd130;
  localparam logic [7:0] IDX_CFG3      = 8'd131;
  localparam logic [7:0] IDX_LLADDR    = 8'd136;
  localparam logic [7:0] IDX_DBG       = 8'd184;

  // fixed field positions
  localparam int unsigned TSTATE_ACT_BIT = 13;
  localparam int unsigned TSTATE_DYN_BIT = 15;
  localparam int unsigned THALT_H_BIT    = 0;
  localparam int unsigned TBIND_VP_LSB   = 0;
  localparam int unsigned TBIND_VP_W     = 4;
  localparam int unsigned TBIND_TC_LSB   = 21;
  localparam int unsigned MPCFG_PTC_LSB  = 0;
  localparam int unsigned MPCFG_PTC_W    = 8;
  localparam int unsigned MPCFG_PVP_LSB  = 10;
  localparam int unsigned MPCFG_TCA_BIT  = 15;
  localparam int unsigned VPCFG_MVP_BIT  = 1;
  localparam int unsigned STAT_ERL_BIT   = 2;
  localparam int unsigned STAT_BEV_BIT   = 22;

  function automatic bank_e bank_of(logic [7:0] idx);
    if (idx inside {[8'd9:8'd15], [8'd49:8'd53], IDX_EXCBASE})
      return BK_VP;
    if (idx inside {[8'd17:8'd23], IDX_STATUS, IDX_LLADDR, IDX_DBG})
      return BK_TC;
    if (idx inside {IDX_TLB_INDEX, IDX_MP_CTL, IDX_MP_CFG, IDX_RAND, IDX_ENTLO0,
                    IDX_ENTLO1, IDX_CTX, IDX_PGMASK, IDX_WIRED, IDX_BADVA,
                    IDX_IRQCTL, IDX_SHADOW, IDX_CAUSE, IDX_PROCID,
                    [IDX_CFG0:IDX_CFG3]})
      return BK_ONE;
    return BK_NONE;
  endfunction

  function automatic logic [DW-1:0] mask_of(logic [7:0] idx);
    case (idx)
      IDX_STATUS:               return 32'hFF78_FF17;
      IDX_CFG0:                 return 32'h7FFF_0007;
      IDX_CFG2:                 return 32'h7000_F000;
      IDX_EXCBASE:              return 32'h3FFF_F000;
      IDX_SHADOW:               return 32'h0000_F3C0;
      IDX_IRQCTL:               return 32'h0000_03E0;
      IDX_CAUSE:                return 32'h08C0_0300;
      IDX_TLB_INDEX:            return 32'h7FFF_FFFF;
      IDX_ENTLO0, IDX_ENTLO1:   return 32'h3FFF_FFFF;
      IDX_CTX:                  return 32'hFF80_0000;
      IDX_PGMASK:               return 32'h1FFF_F800;
      IDX_PROCID, IDX_CFG1, IDX_CFG3, IDX_RAND, IDX_BADVA, IDX_LLADDR:
                                return '0;
      default:                  return '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] reset_val(logic [7:0] idx, int unsigned copy,
                                              int unsigned ntc, int unsigned nvp);
    logic [DW-1:0] v;
    v = '0;
    case (idx)
      IDX_STATUS:  begin v[STAT_ERL_BIT] = 1'b1; v[STAT_BEV_BIT] = 1'b1; end
      IDX_RAND:    v = 32'd63;
      IDX_EXCBASE: v[31] = 1'b1;
      IDX_MP_CFG: begin
        v[MPCFG_TCA_BIT] = 1'b1;
        v[MPCFG_PVP_LSB +: 4] = 4'(nvp - 1);
        v[MPCFG_PTC_LSB +: MPCFG_PTC_W] = 8'(ntc - 1);
      end
      IDX_VP_CFG:  v[VPCFG_MVP_BIT] = 1'b1;
      IDX_TBIND:   v[TBIND_TC_LSB +: 8] = 8'(copy);
      IDX_TSTATE:  if (copy == 0) v[TSTATE_ACT_BIT] = 1'b1;
                   else           v[TSTATE_DYN_BIT] = 1'b1;
      default:     v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
#(
  parameter int unsigned NUM_TC = 4,
  parameter int unsigned NUM_VP = 2,
  parameter int unsigned TCW    = 2,
  parameter int unsigned CW     = 2
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [TCW-1:0]        tc_i,
  input  logic [TBIND_VP_W-1:0] bind_vp_i,
  output logic                  impl_o,
  output logic [CW-1:0]         copy_o,
  output logic [DW-1:0]         mask_o
);
  bank_e bank;

  always_comb begin
    bank   = bank_of(idx_i);
    impl_o = (bank != BK_NONE);
    mask_o = mask_of(idx_i);
    copy_o = '0;
    case (bank)
      BK_TC: if (32'(tc_i) < NUM_TC) copy_o = CW'(tc_i);
      BK_VP: if (32'(bind_vp_i) < NUM_VP) copy_o = CW'(bind_vp_i);
      default: copy_o = '0;
    endcase
  end
endmodule

// File: rtl/ctl_run_eval.sv
module ctl_run_eval
  import ctl_reg_pkg::*;
#(
  parameter int unsigned NUM_TC = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fire_i,
  input  logic [NUM_TC-1:0]      halt_i,
  input  logic [NUM_TC-1:0]      act_i,
  input  logic [MPCFG_PTC_W-1:0] ptc_i,
  output logic [NUM_TC-1:0]      run_o,
  output logic                   pending_o
);
  logic [NUM_TC-1:0] run_q;
  logic              pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      run_q     <= NUM_TC'(1);
    end else if (pending_q) begin
      pending_q <= 1'b0;
      for (int t = 0; t < NUM_TC; t++)
        if (t <= int'(ptc_i)) run_q[t] <= !halt_i[t] && act_i[t];
    end else if (fire_i) begin
      pending_q <= 1'b1;
    end
  end

  assign run_o     = run_q;
  assign pending_o = pending_q;

  // R9
  eval_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !pending_q |=> pending_q);
  // R10
  single_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |=> !pending_q);
  // R9
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pending_q |=> $stable(run_q));
  // R11
  run_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_q |=> run_q[0] == $past(!halt_i[0] && act_i[0]));
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter int unsigned NUM_TC = 4,
  parameter int unsigned NUM_VP = 2,
  localparam int unsigned TCW      = (NUM_TC > 1) ? $clog2(NUM_TC) : 1,
  localparam int unsigned MAX_COPY = (NUM_TC > NUM_VP) ? NUM_TC : NUM_VP,
  localparam int unsigned CW       = (MAX_COPY > 1) ? $clog2(MAX_COPY) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TCW-1:0]    rd_tc_i,
  output logic [DW-1:0]     rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TCW-1:0]    wr_tc_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              raw_en_i,
  input  logic [IDX_W-1:0]  raw_idx_i,
  input  logic [TCW-1:0]    raw_tc_i,
  input  logic [DW-1:0]     raw_data_i,
  output logic [NUM_TC-1:0] run_o,
  output logic              eval_pending_o
);
  logic [DW-1:0] regs_q [NUM_IDX][MAX_COPY];

  // per-port decode
  logic [IDX_W-1:0]      p_idx  [3];
  logic [TCW-1:0]        p_tc   [3];
  logic [TBIND_VP_W-1:0] p_bind [3];
  logic                  p_impl [3];
  logic [CW-1:0]         p_copy [3];
  logic [DW-1:0]         p_mask [3];

  assign p_idx[0] = rd_idx_i;  assign p_tc[0] = rd_tc_i;
  assign p_idx[1] = wr_idx_i;  assign p_tc[1] = wr_tc_i;
  assign p_idx[2] = raw_idx_i; assign p_tc[2] = raw_tc_i;

  for (genvar p = 0; p < 3; p++) begin : g_port
    assign p_bind[p] = regs_q[IDX_TBIND][CW'(p_tc[p])][TBIND_VP_LSB +: TBIND_VP_W];
    ctl_reg_decode #(.NUM_TC(NUM_TC), .NUM_VP(NUM_VP), .TCW(TCW), .CW(CW)) u_dec (
      .idx_i    (p_idx[p]),
      .tc_i     (p_tc[p]),
      .bind_vp_i(p_bind[p]),
      .impl_o   (p_impl[p]),
      .copy_o   (p_copy[p]),
      .mask_o   (p_mask[p])
    );
  end

  logic          wr_go, raw_go, collide;
  logic [DW-1:0] wr_old, wr_merged;

  assign wr_go     = wr_en_i && p_impl[1];
  assign raw_go    = raw_en_i && p_impl[2];
  assign collide   = wr_go && (wr_idx_i == raw_idx_i) && (p_copy[1] == p_copy[2]);
  assign wr_old    = regs_q[wr_idx_i][p_copy[1]];
  assign wr_merged = (wr_data_i & p_mask[1]) | (wr_old & ~p_mask[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_IDX; i++)
        for (int c = 0; c < MAX_COPY; c++)
          regs_q[i][c] <= reset_val(8'(i), c, NUM_TC, NUM_VP);
    end else begin
      if (raw_go && !collide) regs_q[raw_idx_i][p_copy[2]] <= raw_data_i;
      if (wr_go)              regs_q[wr_idx_i][p_copy[1]]  <= wr_merged;
    end
  end

  assign rd_data_o = p_impl[0] ? regs_q[rd_idx_i][p_copy[0]] : '0;

  // run-control inputs
  logic [NUM_TC-1:0] halt_v, act_v;
  for (genvar t = 0; t < NUM_TC; t++) begin : g_thr
    assign halt_v[t] = regs_q[IDX_THALT][t][THALT_H_BIT];
    assign act_v[t]  = regs_q[IDX_TSTATE][t][TSTATE_ACT_BIT];
  end

  ctl_run_eval #(.NUM_TC(NUM_TC)) u_eval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (wr_go),
    .halt_i   (halt_v),
    .act_i    (act_v),
    .ptc_i    (regs_q[IDX_MP_CFG][0][MPCFG_PTC_LSB +: MPCFG_PTC_W]),
    .run_o    (run_o),
    .pending_o(eval_pending_o)
  );

  // R4
  masked_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> ((regs_q[$past(wr_idx_i)][$past(p_copy[1])] ^ $past(wr_old))
               & ~$past(p_mask[1])) == '0);
  // R5
  raw_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_go && !collide |=> regs_q[$past(raw_idx_i)][$past(p_copy[2])] == $past(raw_data_i));
  // R1
  unimpl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_of(rd_idx_i) == BK_NONE) |-> rd_data_o == '0);
endmodule

// File: tb/ctl_reg_bank_tb.sv
module ctl_reg_bank_tb;
  localparam int NTC = 4;
  localparam int NVP = 2;

  localparam logic [7:0] I_TLB = 0, I_MPCFG = 2, I_UNIMP = 5, I_RAND = 8, I_VPCFG = 10,
                         I_TSTATE = 17, I_TBIND = 18, I_THALT = 20, I_STATUS = 96,
                         I_IRQ = 97, I_PROCID = 120, I_EXCB = 121;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  rd_idx = '0, wr_idx = '0, raw_idx = '0;
  logic [1:0]  rd_tc = '0, wr_tc = '0, raw_tc = '0;
  logic        wr_en = 1'b0, raw_en = 1'b0;
  logic [31:0] wr_data = '0, raw_data = '0;
  logic [31:0] rd_data;
  logic [NTC-1:0] run;
  logic        pend;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctl_reg_bank #(.NUM_TC(NTC), .NUM_VP(NVP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_idx_i(rd_idx), .rd_tc_i(rd_tc), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tc_i(wr_tc), .wr_data_i(wr_data),
    .raw_en_i(raw_en), .raw_idx_i(raw_idx), .raw_tc_i(raw_tc), .raw_data_i(raw_data),
    .run_o(run), .eval_pending_o(pend)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] idx, logic [1:0] tc, logic [31:0] exp);
    rd_idx = idx; rd_tc = tc;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic mw(logic [7:0] idx, logic [1:0] tc, logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_tc = tc; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rw(logic [7:0] idx, logic [1:0] tc, logic [31:0] d);
    raw_en = 1'b1; raw_idx = idx; raw_tc = tc; raw_data = d;
    @(posedge clk); @(negedge clk);
    raw_en = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R7 status", I_STATUS, 0, 32'h0040_0004);
    rd_chk("R7 rand", I_RAND, 0, 32'd63);
    rd_chk("R7 excbase", I_EXCB, 0, 32'h8000_0000);
    rd_chk("R7 mpcfg", I_MPCFG, 0, 32'h0000_8403);
    rd_chk("R7 vpcfg", I_VPCFG, 0, 32'h0000_0002);
    rd_chk("R7 bind t2", I_TBIND, 2, 32'h0040_0000);
    rd_chk("R7 halt t3", I_THALT, 3, 32'h0);
    rd_chk("R8 tstate t0", I_TSTATE, 0, 32'h0000_2000);
    rd_chk("R8 tstate t1", I_TSTATE, 1, 32'h0000_8000);
    check("R12 run", 32'(run), 32'h1);
    check("R12 pending", 32'(pend), 32'h0);
  endtask

  task automatic t_unimpl();
    mw(I_UNIMP, 0, 32'hFFFF_FFFF);
    rw(I_UNIMP, 0, 32'hFFFF_FFFF);
    rd_chk("R1 unimpl", I_UNIMP, 0, 32'h0);
    tick();
  endtask

  task automatic t_thread_bank();
    mw(I_STATUS, 1, 32'hFFFF_FFFF);
    rd_chk("R4 status t1", I_STATUS, 1, 32'hFF78_FF17);
    rd_chk("R2 status t0 kept", I_STATUS, 0, 32'h0040_0004);
    tick();
    mw(I_STATUS, 2, 32'h0);
    rd_chk("R4 status t2 clear", I_STATUS, 2, 32'h0);
    tick();
  endtask

  task automatic t_readonly();
    mw(I_PROCID, 0, 32'hDEAD_BEEF);
    rd_chk("R4 procid ro", I_PROCID, 0, 32'h0);
    tick();
    mw(I_RAND, 0, 32'h0);
    rd_chk("R4 rand ro", I_RAND, 0, 32'd63);
    tick();
    rw(I_PROCID, 0, 32'h1234_5678);
    rd_chk("R5 raw procid", I_PROCID, 0, 32'h1234_5678);
    check("R9 raw no pending", 32'(pend), 32'h0);
  endtask

  task automatic t_collide();
    wr_en = 1'b1; wr_idx = I_IRQ; wr_tc = 0; wr_data = 32'h0;
    raw_en = 1'b1; raw_idx = I_IRQ; raw_tc = 0; raw_data = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; raw_en = 1'b0;
    rd_chk("R6 collision", I_IRQ, 0, 32'h0);
    tick();
  endtask

  task automatic t_vp_bank();
    mw(I_EXCB, 0, 32'h1234_5000);
    rd_chk("R4 excbase vp0", I_EXCB, 0, 32'h9234_5000);
    tick();
    rw(I_TBIND, 1, 32'h0020_0001);
    rd_chk("R3 excbase vp1 reset", I_EXCB, 1, 32'h8000_0000);
    mw(I_EXCB, 1, 32'h0000_1000);
    tick();
    rd_chk("R3 excbase vp1", I_EXCB, 1, 32'h8000_1000);
    rd_chk("R3 excbase vp0 kept", I_EXCB, 0, 32'h9234_5000);
    rw(I_TBIND, 3, 32'h0060_0005);
    rd_chk("R3 out of range", I_EXCB, 3, 32'h9234_5000);
  endtask

  task automatic t_eval();
    mw(I_TSTATE, 1, 32'h0000_2000);
    check("R9 pending set", 32'(pend), 32'h1);
    check("R9 run not yet", 32'(run), 32'h1);
    tick();
    check("R11 run t1", 32'(run), 32'h3);
    check("R9 pending clear", 32'(pend), 32'h0);
    mw(I_THALT, 0, 32'h1);
    tick();
    check("R11 halt t0", 32'(run), 32'h2);
    rw(I_THALT, 0, 32'h0);
    tick(); tick();
    check("R9 raw no eval", 32'(run), 32'h2);
    mw(I_TLB, 0, 32'h5);
    tick();
    check("R11 t0 resumed", 32'(run), 32'h3);
  endtask

  task automatic t_no_resched();
    mw(I_TLB, 0, 32'h1);
    mw(I_THALT, 1, 32'h1);
    check("R10 old state used", 32'(run), 32'h3);
    check("R10 pending clear", 32'(pend), 32'h0);
    tick();
    check("R10 no second eval", 32'(run), 32'h3);
    mw(I_TLB, 0, 32'h2);
    tick();
    check("R11 t1 halted", 32'(run), 32'h1);
  endtask

  task automatic t_limit();
    mw(I_MPCFG, 0, 32'h0000_8400);
    tick();
    rd_chk("R4 mpcfg writable", I_MPCFG, 0, 32'h0000_8400);
    mw(I_TSTATE, 2, 32'h0000_2000);
    tick();
    check("R11 above limit kept", 32'(run), 32'h1);
    mw(I_MPCFG, 0, 32'h0000_8403);
    tick();
    check("R11 full limit", 32'(run), 32'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_unimpl();
    t_thread_bank();
    t_readonly();
    t_collide();
    t_vp_bank();
    t_eval();
    t_no_resched();
    t_limit();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule